// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O Unit

This unit connects a byte-wide processor bus to three 8-bit parallel ports. Ports A and B each have an output latch and a separate input path. Port C is handled as two 4-bit halves. The processor reaches four locations through a 2-bit address: port A, port B, port C and a control location. Reads and writes are single-cycle pulses, qualified by a chip select and taken at the rising clock edge.

Two groups are configured from the control location. Group A holds port A and the upper half of port C. Group B holds port B and the lower half of port C. Each group can run as plain latched I/O or as a strobed port whose handshake lines are borrowed from port C. Port A can also run in a simple bidirectional form. A second control-word form sets or clears one port C latch bit without touching the others.

Handshake inputs arrive from the pins without any relation to the clock. Each one passes through a synchronizer, and its falling edge is detected on the clock domain.

Top module: `tri_port_pio`

## Requirements
- R1: After reset, every pin driver is off (`pa_oe`=0, `pb_oe`=0, `pc_oe`=0x00) and every output latch reads as 0.
- R2: A write to address 3 with data bit 7 = 1 is a configuration word. Its fields are:
  - bits 6:5: group A mode (00 basic, 01 strobed, 1x bidirectional)
  - bit 4: port A direction (1 = input)
  - bit 3: upper port C direction (1 = input)
  - bit 2: group B mode (0 basic, 1 strobed)
  - bit 1: port B direction (1 = input)
  - bit 0: lower port C direction (1 = input)

  The same write clears all output latches and all handshake flags.
- R3: A write to address 3 with bit 7 = 0 sets port C latch bit number wdata[3:1] to wdata[0] and leaves the other seven latch bits unchanged.
- R4: In basic mode, a port set to output shows the last byte written to it on its output pins with the driver enabled. A read of that port returns that byte.
- R5: In basic mode, a port set to input is not driven, and a read returns the live pin value with no latching.
- R6: The two halves of port C take their directions independently. The C read value is, per bit, the driven value for driven bits and the pin value otherwise.
- R7: In strobed input mode, a falling edge on the strobe pin latches the port pins and sets the buffer-full flag. A read of the port returns the latched byte even after the pins change, and clears the flag. The pin assignments are:
  - group A: strobe on pin C4, flag on C5
  - group B: strobe on C2, flag on C1
- R8: In strobed output mode, a write of the port drives the active-low buffer-full line low. A falling edge on the acknowledge pin returns it high. The pin assignments are:
  - group A: full line on C7, acknowledge on C6
  - group B: full line on C1, acknowledge on C2
- R9: The interrupt line (C3 for group A, C0 for group B) is high when an enable is set and either of these holds:
  - an input side has its buffer full
  - an output side has its buffer not full

  The enables are port C latch bits: bit 4 for the A input side, bit 6 for the A output side, bit 2 for group B.
- R10: In bidirectional mode, port A drives its pins only while the acknowledge pin C6 (after synchronizing) is low. The output handshake (C7, C6) and the input handshake (C4, C5) both work, and C3 carries the interrupt.
- R11: A handshake pin edge takes effect within three clock edges after the pin falls. Pins that carry handshake inputs are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies rd and wr |
| rd | input | 1 | Read pulse, one cycle |
| wr | input | 1 | Write pulse, one cycle |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 1 | Port A driver enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output value |
| pb_oe | output | 1 | Port B driver enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output value per bit |
| pc_oe | output | 8 | Port C driver enable per bit |

## Verification
Basic mode is driven with random bytes in both directions. These tell a latched output apart from an unlatched input, and show whether the two port C halves keep separate directions. Random single-bit control words on random port C bytes check that exactly one bit moves. Directed strobe and acknowledge pulses cover the following:
- both groups in strobed mode, and the bidirectional form of port A
- the pin changes after latching, to show that the read returns the held byte
- interrupts with the enable both clear and set, to separate flag state from interrupt gating

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] SEL_A   = 2'd0;
  localparam logic [1:0] SEL_B   = 2'd1;
  localparam logic [1:0] SEL_C   = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // Port C pin roles in the strobed and bidirectional modes
  localparam int unsigned PC_A_FULLN = 7;
  localparam int unsigned PC_A_ACK   = 6;
  localparam int unsigned PC_A_IBF   = 5;
  localparam int unsigned PC_A_STB   = 4;
  localparam int unsigned PC_A_IRQ   = 3;
  localparam int unsigned PC_B_HS    = 2;
  localparam int unsigned PC_B_FLAG  = 1;
  localparam int unsigned PC_B_IRQ   = 0;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/tpp_sync_fall.sv
module tpp_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[LAST];
    end
  end

  assign lvl  = sh_q[LAST];
  assign fall = prev_q & ~sh_q[LAST];
endmodule

// File: rtl/tpp_ctrl.sv
module tpp_ctrl
  import tpp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic              wr_c,
  input  logic [BYTE_W-1:0] wdata,
  output cfg_t              cfg,
  output logic [BYTE_W-1:0] a_lat,
  output logic [BYTE_W-1:0] b_lat,
  output logic [BYTE_W-1:0] pc_lat,
  output logic              mode_set
);
  cfg_t              cfg_q, cfg_d;
  logic [BYTE_W-1:0] a_q, a_d, b_q, b_d, c_q, c_d;
  logic              en;

  assign mode_set = wr_ctl & wdata[7];
  assign en       = wr_ctl | wr_a | wr_b | wr_c;

  always_comb begin
    cfg_d = cfg_q;
    a_d   = a_q;
    b_d   = b_q;
    c_d   = c_q;
    if (mode_set) begin
      cfg_d = cfg_t'(wdata[6:0]);
      a_d   = '0;
      b_d   = '0;
      c_d   = '0;
    end else if (wr_ctl) begin
      c_d[wdata[3:1]] = wdata[0];
    end
    if (wr_a) a_d = wdata;
    if (wr_b) b_d = wdata;
    if (wr_c) c_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
    end else if (en) begin
      cfg_q <= cfg_d;
      a_q   <= a_d;
      b_q   <= b_d;
      c_q   <= c_d;
    end
  end

  assign cfg    = cfg_q;
  assign a_lat  = a_q;
  assign b_lat  = b_q;
  assign pc_lat = c_q;
endmodule

// File: rtl/tpp_hs_chan.sv
module tpp_hs_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_en,
  input  logic         out_en,
  input  logic         stb_fall,
  input  logic         ack_fall,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [W-1:0] din,
  output logic [W-1:0] in_lat,
  output logic         ibf,
  output logic         obf
);
  logic [W-1:0] lat_q, lat_d;
  logic         ibf_q, ibf_d, obf_q, obf_d;
  logic         en;

  assign en = clr | in_en | out_en;

  always_comb begin
    lat_d = lat_q;
    ibf_d = ibf_q;
    obf_d = obf_q;
    if (clr) begin
      lat_d = '0;
      ibf_d = 1'b0;
      obf_d = 1'b0;
    end else begin
      if (in_en && stb_fall) begin
        lat_d = din;
        ibf_d = 1'b1;
      end else if (in_en && rd_hit) begin
        ibf_d = 1'b0;
      end
      if (out_en && wr_hit) begin
        obf_d = 1'b1;
      end else if (out_en && ack_fall) begin
        obf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
    end else if (en) begin
      lat_q <= lat_d;
      ibf_q <= ibf_d;
      obf_q <= obf_d;
    end
  end

  assign in_lat = lat_q;
  assign ibf    = ibf_q;
  assign obf    = obf_q;
endmodule

// File: rtl/tpp_pcmap.sv
module tpp_pcmap
  import tpp_pkg::*;
(
  input  cfg_t              cfg,
  input  logic [BYTE_W-1:0] pc_lat,
  input  logic              ibf_a,
  input  logic              obf_a,
  input  logic              ibf_b,
  input  logic              obf_b,
  input  logic              irq_a,
  input  logic              irq_b,
  output logic [BYTE_W-1:0] pc_out,
  output logic [BYTE_W-1:0] pc_oe
);
  localparam int unsigned HALF = BYTE_W / 2;

  always_comb begin
    pc_out = pc_lat;
    pc_oe  = {{HALF{~cfg.cu_in}}, {HALF{~cfg.cl_in}}};
    if (cfg.a_mode[1]) begin
      pc_out[PC_A_FULLN] = ~obf_a;
      pc_oe[PC_A_FULLN]  = 1'b1;
      pc_oe[PC_A_ACK]    = 1'b0;
      pc_out[PC_A_IBF]   = ibf_a;
      pc_oe[PC_A_IBF]    = 1'b1;
      pc_oe[PC_A_STB]    = 1'b0;
      pc_out[PC_A_IRQ]   = irq_a;
      pc_oe[PC_A_IRQ]    = 1'b1;
    end else if (cfg.a_mode[0]) begin
      pc_out[PC_A_IRQ] = irq_a;
      pc_oe[PC_A_IRQ]  = 1'b1;
      if (cfg.a_in) begin
        pc_oe[PC_A_STB]  = 1'b0;
        pc_out[PC_A_IBF] = ibf_a;
        pc_oe[PC_A_IBF]  = 1'b1;
      end else begin
        pc_out[PC_A_FULLN] = ~obf_a;
        pc_oe[PC_A_FULLN]  = 1'b1;
        pc_oe[PC_A_ACK]    = 1'b0;
      end
    end
    if (cfg.b_mode) begin
      pc_oe[PC_B_HS]    = 1'b0;
      pc_out[PC_B_FLAG] = cfg.b_in ? ibf_b : ~obf_b;
      pc_oe[PC_B_FLAG]  = 1'b1;
      pc_out[PC_B_IRQ]  = irq_b;
      pc_oe[PC_B_IRQ]   = 1'b1;
    end
  end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import tpp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] pa_in,
  output logic [BYTE_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic [BYTE_W-1:0] pb_in,
  output logic [BYTE_W-1:0] pb_out,
  output logic              pb_oe,
  input  logic [BYTE_W-1:0] pc_in,
  output logic [BYTE_W-1:0] pc_out,
  output logic [BYTE_W-1:0] pc_oe
);
  localparam int unsigned HS_N = 3;

  cfg_t              cfg;
  logic [BYTE_W-1:0] a_lat, b_lat, pc_lat;
  logic              mode_set;
  logic              wr_a, wr_b, wr_c, wr_ctl, rd_a, rd_b;
  logic              a_m1, a_m2, a_in_en, a_out_en, b_in_en, b_out_en;
  logic [HS_N-1:0]   hs_pin, hs_lvl, hs_fall;
  logic [BYTE_W-1:0] in_lat_a, in_lat_b;
  logic              ibf_a, obf_a, ibf_b, obf_b, irq_a, irq_b;

  assign wr_a   = cs & wr & (addr == SEL_A);
  assign wr_b   = cs & wr & (addr == SEL_B);
  assign wr_c   = cs & wr & (addr == SEL_C);
  assign wr_ctl = cs & wr & (addr == SEL_CTL);
  assign rd_a   = cs & rd & (addr == SEL_A);
  assign rd_b   = cs & rd & (addr == SEL_B);

  tpp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_a(wr_a), .wr_b(wr_b),
    .wr_c(wr_c), .wdata(wdata), .cfg(cfg), .a_lat(a_lat), .b_lat(b_lat),
    .pc_lat(pc_lat), .mode_set(mode_set)
  );

  assign a_m1     = (cfg.a_mode == 2'b01);
  assign a_m2     = cfg.a_mode[1];
  assign a_in_en  = (a_m1 & cfg.a_in) | a_m2;
  assign a_out_en = (a_m1 & ~cfg.a_in) | a_m2;
  assign b_in_en  = cfg.b_mode & cfg.b_in;
  assign b_out_en = cfg.b_mode & ~cfg.b_in;

  // index 0: group B strobe/ack, 1: group A strobe, 2: group A ack
  assign hs_pin = {pc_in[PC_A_ACK], pc_in[PC_A_STB], pc_in[PC_B_HS]};

  for (genvar g = 0; g < HS_N; g++) begin : g_sync
    tpp_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(hs_pin[g]), .lvl(hs_lvl[g]), .fall(hs_fall[g])
    );
  end

  tpp_hs_chan #(.W(BYTE_W)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .in_en(a_in_en), .out_en(a_out_en),
    .stb_fall(hs_fall[1]), .ack_fall(hs_fall[2]), .rd_hit(rd_a), .wr_hit(wr_a),
    .din(pa_in), .in_lat(in_lat_a), .ibf(ibf_a), .obf(obf_a)
  );

  tpp_hs_chan #(.W(BYTE_W)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .in_en(b_in_en), .out_en(b_out_en),
    .stb_fall(hs_fall[0]), .ack_fall(hs_fall[0]), .rd_hit(rd_b), .wr_hit(wr_b),
    .din(pb_in), .in_lat(in_lat_b), .ibf(ibf_b), .obf(obf_b)
  );

  assign irq_a = (a_in_en & ibf_a & pc_lat[PC_A_STB]) |
                 (a_out_en & ~obf_a & pc_lat[PC_A_ACK]);
  assign irq_b = ((b_in_en & ibf_b) | (b_out_en & ~obf_b)) & pc_lat[PC_B_HS];

  tpp_pcmap u_pcmap (
    .cfg(cfg), .pc_lat(pc_lat), .ibf_a(ibf_a), .obf_a(obf_a), .ibf_b(ibf_b),
    .obf_b(obf_b), .irq_a(irq_a), .irq_b(irq_b), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  assign pa_out = a_lat;
  assign pb_out = b_lat;
  assign pa_oe  = a_m2 ? ~hs_lvl[2] : ~cfg.a_in;
  assign pb_oe  = ~cfg.b_in;

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      unique case (addr)
        SEL_A:   rdata = a_in_en ? in_lat_a :
                         ((cfg.a_mode == 2'b00) && cfg.a_in) ? pa_in : a_lat;
        SEL_B:   rdata = b_in_en ? in_lat_b :
                         (!cfg.b_mode && cfg.b_in) ? pb_in : b_lat;
        SEL_C:   rdata = (pc_oe & pc_out) | (~pc_oe & pc_in);
        default: rdata = {1'b1, cfg};
      endcase
    end
  end
endmodule

// File: rtl/tpp_chk.sv
module tpp_chk
  import tpp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              rd,
  input logic              wr,
  input logic [1:0]        addr,
  input logic [BYTE_W-1:0] wdata,
  input logic              pa_oe,
  input logic [BYTE_W-1:0] pa_out,
  input logic [BYTE_W-1:0] pb_out,
  input logic [BYTE_W-1:0] pc_lat,
  input logic              ibf_a,
  input logic              obf_a,
  input logic              a_in_en,
  input logic              a_out_en,
  input cfg_t              cfg,
  input logic              stb_fall_a
);
  logic ctl_wr;
  assign ctl_wr = cs && wr && (addr == SEL_CTL);

  a_r2_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && pc_lat == '0));

  a_r3_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[7]) |=>
      ($countones(pc_lat ^ $past(pc_lat)) <= 1 && pc_lat[$past(wdata[3:1])] == $past(wdata[0])));

  a_r5_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.a_mode == 2'b00 && cfg.a_in) |-> !pa_oe);

  a_r7_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && addr == SEL_A && a_in_en && !stb_fall_a) |=> !ibf_a);

  a_r8_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == SEL_A && a_out_en) |=> obf_a);
endmodule

bind tri_port_pio tpp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .pa_oe(pa_oe), .pa_out(pa_out), .pb_out(pb_out), .pc_lat(pc_lat),
  .ibf_a(ibf_a), .obf_a(obf_a), .a_in_en(a_in_en), .a_out_en(a_out_en),
  .cfg(cfg), .stb_fall_a(hs_fall[1])
);

// File: tb/tri_port_pio_tb.sv
module tri_port_pio_tb;
  logic       clk, rst_n, cs, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, pa_in, pa_out, pb_in, pb_out, pc_in, pc_out, pc_oe;
  logic       pa_oe, pb_oe;
  int         n_chk, n_bad;

  tri_port_pio u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] bsr_apply(logic [7:0] base, logic [7:0] cw);
    logic [7:0] r;
    r = base;
    r[cw[3:1]] = cw[0];
    return r;
  endfunction

  function automatic logic [7:0] c_read(logic [7:0] pins, logic [7:0] drv, logic [7:0] oe);
    return (oe & drv) | (~oe & pins);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #2 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic pulse_low(int idx);
    @(negedge clk);
    pc_in[idx] = 1'b0;
    repeat (2) @(negedge clk);
    pc_in[idx] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, x, y, base, cw;
    n_chk = 0; n_bad = 0;
    cs = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    pa_in = 0; pb_in = 0; pc_in = 8'hFF;
    d = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", {6'd0, pa_oe, pb_oe}, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);

    // R4 basic output, random bytes
    bus_wr(2'd3, 8'h80);
    for (int i = 0; i < 20; i++) begin
      x = 8'($urandom); y = 8'($urandom); base = 8'($urandom);
      bus_wr(2'd0, x); bus_wr(2'd1, y); bus_wr(2'd2, base);
      chk("R4 pa_out", pa_out, x);
      chk("R4 pb_out", pb_out, y);
      chk("R4 pc_out", pc_out, base);
      chk("R4 oe", {5'd0, pa_oe, pb_oe, pc_oe == 8'hFF}, 8'h07);
      bus_rd(2'd0, d);
      chk("R4 readback", d, x);
    end
    // R2 mode word clears latches
    bus_wr(2'd3, 8'h80);
    chk("R2 pa clear", pa_out, 8'h00);
    chk("R2 pc clear", pc_out, 8'h00);

    // R5/R6 basic input, upper C in, lower C out
    bus_wr(2'd3, 8'h9A);
    for (int i = 0; i < 10; i++) begin
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      x = 8'($urandom);
      bus_wr(2'd2, x);
      bus_rd(2'd0, d); chk("R5 port A live", d, pa_in);
      bus_rd(2'd1, d); chk("R5 port B live", d, pb_in);
      chk("R5 undriven", {6'd0, pa_oe, pb_oe}, 8'h00);
      chk("R6 pc_oe", pc_oe, 8'h0F);
      bus_rd(2'd2, d); chk("R6 C read", d, c_read(pc_in, x, 8'h0F));
    end
    pc_in = 8'hFF;

    // R3 single bit set/reset
    bus_wr(2'd3, 8'h80);
    for (int i = 0; i < 12; i++) begin
      base = 8'($urandom);
      cw = {4'd0, 4'($urandom)};
      bus_wr(2'd2, base);
      bus_wr(2'd3, cw);
      chk("R3 one bit", pc_out, bsr_apply(base, cw));
    end
    base = 8'hFF; bus_wr(2'd2, base); bus_wr(2'd3, 8'h0E);
    chk("R3 clear top bit", pc_out, 8'h7F);

    // R7/R9 group A strobed input
    bus_wr(2'd3, 8'hB0);
    pa_in = 8'h5A;
    pulse_low(4);
    chk("R7 IBF high", {7'd0, pc_out[5]}, 8'h01);
    chk("R9 irq off without enable", {7'd0, pc_out[3]}, 8'h00);
    chk("R11 strobe pin undriven", {7'd0, pc_oe[4]}, 8'h00);
    pa_in = 8'h00;
    bus_rd(2'd0, d);
    chk("R7 held byte", d, 8'h5A);
    chk("R7 IBF cleared", {7'd0, pc_out[5]}, 8'h00);
    bus_wr(2'd3, 8'h09);
    pa_in = 8'h33;
    pulse_low(4);
    chk("R9 irq on", {7'd0, pc_out[3]}, 8'h01);
    bus_rd(2'd0, d);
    chk("R7 second byte", d, 8'h33);
    chk("R9 irq off after read", {7'd0, pc_out[3]}, 8'h00);

    // R8/R9 group A strobed output
    bus_wr(2'd3, 8'hA0);
    chk("R8 full line idle", {7'd0, pc_out[7]}, 8'h01);
    bus_wr(2'd3, 8'h0D);
    chk("R9 irq empty", {7'd0, pc_out[3]}, 8'h01);
    bus_wr(2'd0, 8'hC3);
    chk("R8 full low", {7'd0, pc_out[7]}, 8'h00);
    chk("R8 data", pa_out, 8'hC3);
    chk("R9 irq off full", {7'd0, pc_out[3]}, 8'h00);
    pulse_low(6);
    chk("R8 ack releases", {7'd0, pc_out[7]}, 8'h01);
    chk("R9 irq back", {7'd0, pc_out[3]}, 8'h01);

    // R7 group B strobed input
    bus_wr(2'd3, 8'h86);
    pb_in = 8'h81;
    pulse_low(2);
    chk("R7 B IBF", {7'd0, pc_out[1]}, 8'h01);
    pb_in = 8'h18;
    bus_rd(2'd1, d);
    chk("R7 B held byte", d, 8'h81);
    chk("R7 B IBF cleared", {7'd0, pc_out[1]}, 8'h00);

    // R8 group B strobed output
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd1, 8'h3E);
    chk("R8 B full low", {7'd0, pc_out[1]}, 8'h00);
    pulse_low(2);
    chk("R8 B ack releases", {7'd0, pc_out[1]}, 8'h01);

    // R10 bidirectional port A
    bus_wr(2'd3, 8'hC0);
    chk("R10 idle undriven", {7'd0, pa_oe}, 8'h00);
    bus_wr(2'd0, 8'h77);
    chk("R10 full low", {7'd0, pc_out[7]}, 8'h00);
    @(negedge clk); pc_in[6] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 driven on ack", {7'd0, pa_oe}, 8'h01);
    chk("R10 data on ack", pa_out, 8'h77);
    pc_in[6] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 released", {7'd0, pa_oe}, 8'h00);
    chk("R10 full cleared", {7'd0, pc_out[7]}, 8'h01);
    pa_in = 8'h3C;
    pulse_low(4);
    chk("R10 IBF", {7'd0, pc_out[5]}, 8'h01);
    bus_rd(2'd0, d);
    chk("R10 input byte", d, 8'h3C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule